// File: doc/BRIEF.md
# Segmented DAC Input Front End

This block is the digital front end of an 8-bit voltage-output converter whose upper bits drive equal-weight segments. It takes a data word and an active-high complement control. When the control is high, every data bit is inverted. The block then splits the word into two groups:

- The top three bits become a seven-line thermometer code.
- The bottom five bits pass on as plain binary lines.

All twelve lines go through a latch before they drive the output switches.

The latch is controlled by an active-low enable called `freeze`.

- While `freeze` is low, the twelve lines follow the input.
- A rising edge on `freeze` captures the current lines.
- The captured value is held for as long as `freeze` stays high.

The latch is modelled with the system clock, so the design contains no level-sensitive storage. The clock samples `freeze` once per cycle. The cycle that sees it high while the previous cycle saw it low is the capture point. During transparency the data path stays combinational.

An auxiliary output rebuilds the code that the switch lines stand for. Its value is 32 times the number of asserted thermometer lines plus the binary field.

Top module: `segdac_front`

## Requirements
- R1: After a clock edge at which `freeze` was sampled low and `rst` was low, the outputs follow `code_in` combinationally, with no storage.
- R2: With `invert` high, the effective word is `code_in` with every bit inverted. With `invert` low, the effective word is `code_in` unchanged.
- R3: `therm[i]` is 1 exactly when the effective bits [7:5], read as an unsigned value k, exceed i. So the k lowest lines are set. `bin` equals the effective bits [4:0], with bin[0] weighted 1.
- R4: `therm` is always a contiguous run of ones that starts at bit 0. No other pattern ever appears.
- R5: At a clock edge where `freeze` is sampled high and was sampled low at the edge before, the effective word of that edge is captured.
- R6: While `freeze` stays high after a capture, the outputs keep the captured value. Changes on `code_in` and `invert` have no effect.
- R7: A `freeze` pulse that is high for a single clock edge captures correctly. The outputs hold the captured value for the following cycle.
- R8: Effective code 00 hex gives all twelve lines low. Effective code FF hex gives all twelve lines high.
- R9: The synchronous active-high `rst` clears the held value to zero scale and enters the hold state. The outputs stay at zero scale until `freeze` is sampled low.
- R10: `code_eff` equals 32 times the number of ones in `therm` plus `bin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 8 | Data word, bit 7 most significant |
| invert | input | 1 | Complement control, active high |
| freeze | input | 1 | Latch control: low is transparent, a rising edge captures, high holds |
| therm | output | 7 | Thermometer lines for the three upper bits |
| bin | output | 5 | Binary lines for the five lower bits |
| code_eff | output | 8 | Code rebuilt from the switch lines |

## Verification
Two events can fall in the same cycle: a capture, and a change of `code_in` or `invert`. The bench provokes this by changing the data and the complement control in the very cycle in which `freeze` first goes high. The held value must then equal the word present at that edge, not the word before or after it.

A reset is also applied while `freeze` is rising. This checks that the reset wins and that the outputs return to zero scale.

A behavioural model in the bench tracks the hold state and the captured code. Every cycle, all three outputs are compared with that model.

// File: rtl/segdac_front.sv
module segdac_front #(
  parameter int HI_BITS = 3,
  parameter int LO_BITS = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [HI_BITS+LO_BITS-1:0] code_in,
  input  logic                       invert,
  input  logic                       freeze,
  output logic [(1<<HI_BITS)-2:0]    therm,
  output logic [LO_BITS-1:0]         bin,
  output logic [HI_BITS+LO_BITS-1:0] code_eff
);
  localparam int W     = HI_BITS + LO_BITS;
  localparam int SEGS  = (1 << HI_BITS) - 1;
  localparam int LINES = SEGS + LO_BITS;

  logic [W-1:0]     word;
  logic [SEGS-1:0]  therm_live;
  logic [LINES-1:0] live, held, lines;
  logic             freeze_s;
  logic             capture;
  logic [HI_BITS-1:0] seg_cnt;

  assign word = code_in ^ {W{invert}};

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    assign therm_live[i] = word[W-1:LO_BITS] > HI_BITS'(i);
  end

  assign live    = {therm_live, word[LO_BITS-1:0]};
  assign capture = freeze & ~freeze_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_s <= 1'b1;
      held     <= '0;
    end else begin
      freeze_s <= freeze;
      if (capture) held <= live;
    end
  end

  assign lines = freeze_s ? held : live;
  assign therm = lines[LINES-1:LO_BITS];
  assign bin   = lines[LO_BITS-1:0];

  always_comb begin
    seg_cnt = '0;
    for (int i = 0; i < SEGS; i++)
      seg_cnt = seg_cnt + HI_BITS'(therm[i]);
  end

  assign code_eff = {seg_cnt, bin};
endmodule

// File: rtl/segdac_front_chk.sv
module segdac_front_chk #(
  parameter int HI_BITS = 3,
  parameter int LO_BITS = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic [HI_BITS+LO_BITS-1:0] code_in,
  input logic                       invert,
  input logic                       freeze,
  input logic [(1<<HI_BITS)-2:0]    therm,
  input logic [LO_BITS-1:0]         bin,
  input logic [HI_BITS+LO_BITS-1:0] code_eff
);
  localparam int W = HI_BITS + LO_BITS;

  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  p_follow_r1: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !$past(freeze) && !$past(rst)) |-> code_eff == (code_in ^ {W{invert}}));

  p_contig_r4: assert property (@(posedge clk) disable iff (rst)
    seen_rst |-> ((therm & (therm + 1'b1)) == '0));

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && $past(freeze) && !$past(freeze, 2) && !$past(rst) && !$past(rst, 2))
      |-> code_eff == $past(code_in ^ {W{invert}}));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && $past(freeze) && $past(freeze, 2) && !$past(rst)) |-> $stable(code_eff));

  p_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && $past(rst)) |-> (therm == '0 && bin == '0));
endmodule

bind segdac_front segdac_front_chk #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_chk (
  .clk(clk), .rst(rst), .code_in(code_in), .invert(invert), .freeze(freeze),
  .therm(therm), .bin(bin), .code_eff(code_eff)
);

// File: tb/segdac_front_bench.sv
`timescale 1ns/1ps
module segdac_front_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] code_in = 8'h00;
  logic       invert = 1'b0;
  logic       freeze = 1'b0;
  logic [6:0] therm;
  logic [4:0] bin;
  logic [7:0] code_eff;

  int checks = 0, fails = 0, cycles = 0;
  bit checking = 0;
  bit m_frz = 1'b1;
  logic [7:0] m_held = 8'h00;
  string phase = "R9";

  always #2 clk = ~clk;

  segdac_front u_segdac_front (
    .clk(clk), .rst(rst), .code_in(code_in), .invert(invert), .freeze(freeze),
    .therm(therm), .bin(bin), .code_eff(code_eff)
  );

  function automatic logic [6:0] therm_of(input logic [7:0] c);
    logic [6:0] t = '0;
    for (int i = 0; i < 7; i++) if (int'(c[7:5]) > i) t[i] = 1'b1;
    return t;
  endfunction

  function automatic int ones(input logic [6:0] t);
    int n = 0;
    for (int i = 0; i < 7; i++) n += int'(t[i]);
    return n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_frz  = 1'b1;
      m_held = 8'h00;
    end else begin
      if (freeze && !m_frz) m_held = code_in ^ {8{invert}};
      m_frz = freeze;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking) begin
    logic [7:0] e;
    e = m_frz ? m_held : (code_in ^ {8{invert}});
    chk({phase, " therm R3"}, int'(therm), int'(therm_of(e)));
    chk({phase, " bin R3"}, int'(bin), int'(e[4:0]));
    chk("R10 rebuilt code", int'(code_eff), 32 * ones(therm) + int'(bin));
    chk("R4 contiguous", int'((therm & (therm + 7'd1)) == 7'd0), 1);
  end

  task automatic step(input logic [7:0] c, input logic inv, input logic frz);
    @(posedge clk); #1;
    code_in = c; invert = inv; freeze = frz;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9: reset, then freeze kept high, so the outputs stay at zero scale
    code_in = 8'hA7; freeze = 1'b1;
    repeat (3) @(posedge clk);
    #1 checking = 1;
    step(8'h5C, 1'b0, 1'b1);
    rst = 1'b0;
    step(8'hFF, 1'b1, 1'b1);
    step(8'h3D, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 zero scale after reset", int'(code_eff), 0);

    // R1: transparent sweep
    phase = "R1";
    for (int v = 0; v < 256; v++) step(8'(v), 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 follow input", int'(code_eff), 8'hFF);

    // R2: complement
    phase = "R2";
    for (int v = 0; v < 256; v += 7) step(8'(v), 1'b1, 1'b0);
    step(8'h96, 1'b1, 1'b0);
    @(negedge clk);
    chk("R2 inverted word", int'(code_eff), 8'h69);

    // R8: extremes, with and without complement
    phase = "R8";
    step(8'h00, 1'b0, 1'b0); @(negedge clk);
    chk("R8 zero scale", int'({therm, bin}), 0);
    step(8'hFF, 1'b0, 1'b0); @(negedge clk);
    chk("R8 full scale", int'({therm, bin}), 12'hFFF);
    step(8'hFF, 1'b1, 1'b0); @(negedge clk);
    chk("R8 complemented FF", int'({therm, bin}), 0);
    step(8'h00, 1'b1, 1'b0); @(negedge clk);
    chk("R8 complemented 00", int'({therm, bin}), 12'hFFF);

    // R5: capture with data and complement changing in the capture cycle
    phase = "R5";
    step(8'h11, 1'b0, 1'b0);
    step(8'hC3, 1'b1, 1'b1);
    step(8'h7E, 1'b0, 1'b1);
    @(negedge clk);
    chk("R5 captured word", int'(code_eff), 8'h3C);

    // R6: hold while freeze stays high
    phase = "R6";
    for (int n = 0; n < 20; n++) step(8'($urandom), 1'($urandom), 1'b1);
    @(negedge clk);
    chk("R6 held word", int'(code_eff), 8'h3C);

    // R7: single-cycle pulses
    phase = "R7";
    for (int n = 0; n < 30; n++) begin
      step(8'($urandom), 1'($urandom), 1'b0);
      step(8'($urandom), 1'($urandom), 1'b1);
      step(8'($urandom), 1'($urandom), 1'b0);
    end
    step(8'h00, 1'b0, 1'b0);
    step(8'hE4, 1'b0, 1'b1);
    step(8'h01, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 one-edge pulse captured", int'(code_eff), 8'hE4);

    // R9: reset during a freeze rise
    phase = "R9";
    step(8'h00, 1'b0, 1'b0);
    rst = 1'b1;
    step(8'hF0, 1'b0, 1'b1);
    rst = 1'b0;
    step(8'hAA, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 reset beats capture", int'(code_eff), 0);

    // R3: random mixed traffic
    phase = "R3";
    for (int n = 0; n < 600; n++) step(8'($urandom), 1'($urandom), 1'(($urandom % 3) == 0));
    step(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    checking = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule